// File: doc/BRIEF.md
# Serial NAND Feature Register Target

This block models, on the device side, the small register file that a serial NAND flash exposes over its command interface. A host drives a single-lane SPI link in mode 0: the clock idles low, the host changes MOSI while the clock is low, and both sides sample on the rising edge. The block oversamples SCLK, CS_n and MOSI with its own system clock, so that clock must run at least eight times faster than SCLK. It decodes five one-byte opcodes: read a feature register, write a feature register, set the write-enable latch, clear it, and soft reset.

Three bytes can be reached by a one-byte sub-address: a protection byte, a configuration byte and a status byte. The status byte is put together from live inputs (array busy, ECC state), from sticky program and erase failure flags, and from the write-enable latch. The host cannot write it. The array controller next to this block uses the write-enable latch, the quad-enable bit and the three block-protect bits, which come out on dedicated pins.

Top module: `snf_feature_target`

## Requirements
- R1: After the synchronous reset, the write-enable latch is 0, the protection byte is 0x38, the configuration byte is 0x10, quad_en_o is 0, bp_o is 3'b111 and MISO is 0.
- R2: A read is opcode 0x0F, then an address byte, then one data byte that the block shifts out on MISO, most significant bit first. The block changes MISO after each falling SCLK edge, so the host can sample each bit at the next rising edge.
- R3: A write is opcode 0x1F, then an address byte, then a data byte. Address 0xA0 stores the protection byte and address 0xB0 stores the configuration byte, and a later read of that address returns the value written. bp_o follows bits 5:3 of the protection byte, and quad_en_o follows bit 0 of the configuration byte.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is visible on wel_o and in bit 1 of the status byte.
- R5: The status byte at address 0xC0 is laid out as follows: bit 0 is array_busy_i, sampled when the address byte completes; bit 1 is the write-enable latch; bit 2 is a sticky erase-fail flag, set by a pulse on erase_fail_i; bit 3 is a sticky program-fail flag, set by a pulse on prog_fail_i; bits 5:4 are ecc_state_i; bits 7:6 are 0.
- R6: A write to address 0xC0 changes nothing. The status, protection and configuration bytes all read back as they were before it.
- R7: A read of any address other than 0xA0, 0xB0 or 0xC0 returns 0x00, and a write to such an address changes no register.
- R8: Opcode 0xFF clears the write-enable latch and both fail flags. The protection and configuration bytes keep their values.
- R9: An unknown opcode, and any byte that follows a completed command in the same select period, has no effect. MISO stays 0 outside the data byte of a read.
- R10: When CS_n rises in the middle of a command, the command is abandoned. A write cut short stores nothing, and the next command after reselection is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock from the host, mode 0 |
| cs_n | input | 1 | Active-low target select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| array_busy_i | input | 1 | Array operation in progress |
| prog_fail_i | input | 1 | One-cycle pulse: program failed |
| erase_fail_i | input | 1 | One-cycle pulse: erase failed |
| ecc_state_i | input | 2 | ECC result from the array side |
| wel_o | output | 1 | Write-enable latch |
| quad_en_o | output | 1 | Quad-enable bit of the configuration byte |
| bp_o | output | 3 | Block-protect field of the protection byte |

## Verification
Each result reaches the pins a few system clocks after the SCLK edge that causes it. An effect follows the rising edge of the last bit of its byte by two synchronizer stages plus the edge detect, plus one decode register, plus one register update. A read bit reaches MISO through the same synchronizer after a falling edge. The bench holds each SCLK phase for eight system clocks and samples MISO only just before it raises SCLK. It checks the register pins only several clocks after CS_n rises, so every expected value has settled. The reads are compared by a scoreboard: the transaction task queues the expected byte and a monitor pops it when the read completes.

// File: rtl/snf_pkg.sv
package snf_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_GET  = 8'h0F;
    localparam logic [BYTE_W-1:0] OPC_SET  = 8'h1F;
    localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_WRDI = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_RST  = 8'hFF;

    localparam logic [BYTE_W-1:0] SEL_PROT = 8'hA0;
    localparam logic [BYTE_W-1:0] SEL_CFG  = 8'hB0;
    localparam logic [BYTE_W-1:0] SEL_STAT = 8'hC0;

    localparam int BP_LO    = 3;
    localparam int BP_W     = 3;
    localparam int QUAD_BIT = 0;
    localparam int ECC_W    = 2;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_RD_ADDR,
        PH_WR_ADDR,
        PH_WR_DATA,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic              wren;
        logic              wrdi;
        logic              soft_rst;
        logic              wr;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } reg_cmd_t;

    function automatic logic [BYTE_W-1:0] pack_status(
        input logic             busy,
        input logic             wel,
        input logic             efail,
        input logic             pfail,
        input logic [ECC_W-1:0] ecc
    );
        return {2'b00, ecc, pfail, efail, wel, busy};
    endfunction

endpackage

// File: rtl/snf_spi_front.sv
module snf_spi_front
    import snf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              sel,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              miso
);
    localparam int LAST = SYNC_STAGES - 1;
    localparam int CNT_W = $clog2(BYTE_W);

    logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
    logic                   sclk_d;
    logic                   sclk_now, mosi_now, active, rise, fall;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-1:0]      rx_sh, tx_sh;
    logic                   miso_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk};
            cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
            mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
            sclk_d <= sclk_s[LAST];
        end
    end

    assign sclk_now = sclk_s[LAST];
    assign mosi_now = mosi_s[LAST];
    assign active   = ~cs_s[LAST];
    assign rise     = active & sclk_now & ~sclk_d;
    assign fall     = active & ~sclk_now & sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
            end else if (rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_now};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_vld  <= 1'b1;
                    byte_data <= {rx_sh[BYTE_W-2:0], mosi_now};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (!active) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (load_en) begin
            tx_sh <= load_byte;
        end else if (fall) begin
            miso_q <= tx_sh[BYTE_W-1];
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign sel  = active;
    assign miso = miso_q;

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst) !active |=> !miso_q); // R9

endmodule

// File: rtl/snf_cmd_decoder.sv
module snf_cmd_decoder
    import snf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output reg_cmd_t          cmd,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              load_en
);
    phase_e            phase;
    logic [BYTE_W-1:0] wr_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_OPC;
            wr_addr <= '0;
            rd_addr <= '0;
            load_en <= 1'b0;
            cmd     <= '0;
        end else begin
            cmd.wren     <= 1'b0;
            cmd.wrdi     <= 1'b0;
            cmd.soft_rst <= 1'b0;
            cmd.wr       <= 1'b0;
            load_en      <= 1'b0;
            if (!sel) begin
                phase <= PH_OPC;
            end else if (byte_vld) begin
                unique case (phase)
                    PH_OPC: begin
                        phase <= PH_DONE;
                        case (byte_data)
                            OPC_GET:  phase <= PH_RD_ADDR;
                            OPC_SET:  phase <= PH_WR_ADDR;
                            OPC_WREN: cmd.wren <= 1'b1;
                            OPC_WRDI: cmd.wrdi <= 1'b1;
                            OPC_RST:  cmd.soft_rst <= 1'b1;
                            default:  ;
                        endcase
                    end
                    PH_RD_ADDR: begin
                        rd_addr <= byte_data;
                        load_en <= 1'b1;
                        phase   <= PH_DONE;
                    end
                    PH_WR_ADDR: begin
                        wr_addr <= byte_data;
                        phase   <= PH_WR_DATA;
                    end
                    PH_WR_DATA: begin
                        cmd.wr   <= 1'b1;
                        cmd.addr <= wr_addr;
                        cmd.data <= byte_data;
                        phase    <= PH_DONE;
                    end
                    default: phase <= PH_DONE;
                endcase
            end
        end
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.wren, cmd.wrdi, cmd.soft_rst, cmd.wr, load_en})); // R9

endmodule

// File: rtl/snf_reg_file.sv
module snf_reg_file
    import snf_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PROT_RST = 8'h38,
    parameter logic [BYTE_W-1:0] CFG_RST  = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic              array_busy_i,
    input  logic              prog_fail_i,
    input  logic              erase_fail_i,
    input  logic [ECC_W-1:0]  ecc_state_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic              wel,
    output logic              quad_en,
    output logic [BP_W-1:0]   bp
);
    logic [BYTE_W-1:0] prot_q, cfg_q;
    logic              wel_q, efail_q, pfail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= PROT_RST;
            cfg_q  <= CFG_RST;
        end else if (cmd.wr) begin
            if (cmd.addr == SEL_PROT) prot_q <= cmd.data;
            if (cmd.addr == SEL_CFG)  cfg_q  <= cmd.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q   <= 1'b0;
            efail_q <= 1'b0;
            pfail_q <= 1'b0;
        end else if (cmd.soft_rst) begin
            wel_q   <= 1'b0;
            efail_q <= 1'b0;
            pfail_q <= 1'b0;
        end else begin
            if (cmd.wren) wel_q <= 1'b1;
            if (cmd.wrdi) wel_q <= 1'b0;
            if (erase_fail_i) efail_q <= 1'b1;
            if (prog_fail_i)  pfail_q <= 1'b1;
        end
    end

    always_comb begin
        case (rd_addr)
            SEL_PROT: rd_data = prot_q;
            SEL_CFG:  rd_data = cfg_q;
            SEL_STAT: rd_data = pack_status(array_busy_i, wel_q, efail_q, pfail_q, ecc_state_i);
            default:  rd_data = '0;
        endcase
    end

    assign wel     = wel_q;
    assign quad_en = cfg_q[QUAD_BIT];
    assign bp      = prot_q[BP_LO +: BP_W];

    AST_WEL_SET: assert property (@(posedge clk) disable iff (rst) cmd.wren |=> wel_q); // R4
    AST_WEL_CLR: assert property (@(posedge clk) disable iff (rst) cmd.wrdi |=> !wel_q); // R4
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd.soft_rst |=> (!wel_q && !efail_q && !pfail_q)); // R8
    AST_RST_KEEPS: assert property (@(posedge clk) disable iff (rst)
        cmd.soft_rst |=> ($stable(prot_q) && $stable(cfg_q))); // R8
    AST_STAT_RO: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.addr == SEL_STAT) |=> ($stable(prot_q) && $stable(cfg_q) && $stable(wel_q))); // R6

endmodule

// File: rtl/snf_feature_target.sv
module snf_feature_target
    import snf_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] PROT_RST    = 8'h38,
    parameter logic [BYTE_W-1:0] CFG_RST     = 8'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             miso,
    input  logic             array_busy_i,
    input  logic             prog_fail_i,
    input  logic             erase_fail_i,
    input  logic [1:0]       ecc_state_i,
    output logic             wel_o,
    output logic             quad_en_o,
    output logic [2:0]       bp_o
);
    logic              sel, byte_vld, load_en;
    logic [BYTE_W-1:0] byte_data, rd_addr, rd_data;
    reg_cmd_t          cmd;

    snf_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .load_en(load_en), .load_byte(rd_data),
        .sel(sel), .byte_vld(byte_vld), .byte_data(byte_data), .miso(miso)
    );

    snf_cmd_decoder u_dec (
        .clk(clk), .rst(rst), .sel(sel), .byte_vld(byte_vld), .byte_data(byte_data),
        .cmd(cmd), .rd_addr(rd_addr), .load_en(load_en)
    );

    snf_reg_file #(.PROT_RST(PROT_RST), .CFG_RST(CFG_RST)) u_regs (
        .clk(clk), .rst(rst), .cmd(cmd), .rd_addr(rd_addr),
        .array_busy_i(array_busy_i), .prog_fail_i(prog_fail_i),
        .erase_fail_i(erase_fail_i), .ecc_state_i(ecc_state_i),
        .rd_data(rd_data), .wel(wel_o), .quad_en(quad_en_o), .bp(bp_o)
    );

endmodule

// File: tb/sim_snf_feature_target.sv
module sim_snf_feature_target;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       array_busy_i = 1'b0, prog_fail_i = 1'b0, erase_fail_i = 1'b0;
    logic [1:0] ecc_state_i = 2'b00;
    logic       miso, wel_o, quad_en_o;
    logic [2:0] bp_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_b;
    event       rd_done;

    always #4 clk = ~clk;

    snf_feature_target u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .array_busy_i(array_busy_i), .prog_fail_i(prog_fail_i),
        .erase_fail_i(erase_fail_i), .ecc_state_i(ecc_state_i),
        .wel_o(wel_o), .quad_en_o(quad_en_o), .bp_o(bp_o)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    initial begin
        forever begin
            @(rd_done);
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", got_b, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), got_b, exp_q.pop_front());
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_end();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic get_feat(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        logic [7:0] rx, d0, d1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cs_begin();
        spi_bits(8'h0F, 8, d0);
        spi_bits(addr, 8, d1);
        spi_bits(8'h00, 8, rx);
        cs_end();
        got_b = rx;
        ->rd_done;
        wait_clk(1);
    endtask

    task automatic set_feat(input logic [7:0] addr, input logic [7:0] data);
        logic [7:0] d;
        cs_begin();
        spi_bits(8'h1F, 8, d);
        spi_bits(addr, 8, d);
        spi_bits(data, 8, d);
        cs_end();
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] d;
        cs_begin();
        spi_bits(op, 8, d);
        cs_end();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        wait_clk(100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d, r0, r1;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);

        // R1 reset state
        chk("R1 wel_o", {7'd0, wel_o}, 8'h00);
        chk("R1 quad_en_o", {7'd0, quad_en_o}, 8'h00);
        chk("R1 bp_o", {5'd0, bp_o}, 8'h07);
        chk("R1 miso", {7'd0, miso}, 8'h00);
        get_feat(8'hA0, 8'h38, "R1 R2 protection reset");
        get_feat(8'hB0, 8'h10, "R1 R2 config reset");
        get_feat(8'hC0, 8'h00, "R5 status idle");

        // R4 write-enable latch
        one_op(8'h06);
        chk("R4 wel_o after set", {7'd0, wel_o}, 8'h01);
        get_feat(8'hC0, 8'h02, "R4 status wel");
        one_op(8'h04);
        chk("R4 wel_o after clear", {7'd0, wel_o}, 8'h00);
        get_feat(8'hC0, 8'h00, "R4 status cleared");

        // R3 register writes
        set_feat(8'hA0, 8'h00);
        chk("R3 bp_o cleared", {5'd0, bp_o}, 8'h00);
        get_feat(8'hA0, 8'h00, "R3 protection readback");
        set_feat(8'hB0, 8'h11);
        chk("R3 quad_en_o set", {7'd0, quad_en_o}, 8'h01);
        get_feat(8'hB0, 8'h11, "R3 R2 config readback");
        set_feat(8'hA0, 8'hA6);
        chk("R3 bp_o field", {5'd0, bp_o}, 8'h04);
        get_feat(8'hA0, 8'hA6, "R3 R2 asymmetric readback");

        // R5 status composition
        array_busy_i = 1'b1;
        ecc_state_i  = 2'b10;
        erase_fail_i = 1'b1; wait_clk(1); erase_fail_i = 1'b0;
        get_feat(8'hC0, 8'h25, "R5 busy ecc erase-fail");
        prog_fail_i = 1'b1; wait_clk(1); prog_fail_i = 1'b0;
        get_feat(8'hC0, 8'h2D, "R5 program-fail sticky");
        array_busy_i = 1'b0;
        ecc_state_i  = 2'b01;
        get_feat(8'hC0, 8'h1C, "R5 busy dropped ecc 01");
        ecc_state_i  = 2'b00;

        // R6 status is read-only
        one_op(8'h06);
        set_feat(8'hC0, 8'h00);
        get_feat(8'hC0, 8'h0E, "R6 status unchanged");
        get_feat(8'hA0, 8'hA6, "R6 protection unchanged");
        chk("R6 wel_o kept", {7'd0, wel_o}, 8'h01);

        // R8 soft reset
        one_op(8'hFF);
        chk("R8 wel_o cleared", {7'd0, wel_o}, 8'h00);
        get_feat(8'hC0, 8'h00, "R8 status cleared");
        get_feat(8'hA0, 8'hA6, "R8 protection kept");
        get_feat(8'hB0, 8'h11, "R8 config kept");
        chk("R8 bp_o kept", {5'd0, bp_o}, 8'h04);

        // R7 unknown address
        set_feat(8'h5A, 8'h55);
        get_feat(8'h5A, 8'h00, "R7 unknown reads zero");
        get_feat(8'hA0, 8'hA6, "R7 protection untouched");
        get_feat(8'hB0, 8'h11, "R7 config untouched");

        // R9 unknown opcode and trailing bytes
        cs_begin();
        spi_bits(8'h9F, 8, r0);
        spi_bits(8'h06, 8, r1);
        cs_end();
        chk("R9 wel_o after unknown opcode", {7'd0, wel_o}, 8'h00);
        chk("R9 miso quiet", r0 | r1, 8'h00);
        cs_begin();
        spi_bits(8'h06, 8, r0);
        spi_bits(8'hFF, 8, r1);
        cs_end();
        chk("R9 trailing byte ignored", {7'd0, wel_o}, 8'h01);
        chk("R9 miso quiet after opcode", r0 | r1, 8'h00);

        // R10 abandoned write
        cs_begin();
        spi_bits(8'h1F, 8, d);
        spi_bits(8'hA0, 8, d);
        spi_bits(8'h00, 4, d);
        cs_end();
        get_feat(8'hA0, 8'hA6, "R10 partial write dropped");
        cs_begin();
        spi_bits(8'h04, 5, d);
        cs_end();
        chk("R10 partial opcode no effect", {7'd0, wel_o}, 8'h01);
        one_op(8'h04);
        chk("R10 realigned after abort", {7'd0, wel_o}, 8'h00);

        wait_clk(4);
        if (exp_q.size() != 0) chk("scoreboard leftover", 8'(exp_q.size()), 8'h00);
        done = 1;
        finish_run();
    end

endmodule